// File: doc/BRIEF.md
# AUX Side-Band Traffic Debug Tap

The block watches a half-duplex side-band link, one byte at a time, and turns everything that crosses it into a stream of 32-bit trace words. Each byte becomes one word. The upper 24 bits hold a free-running microsecond stamp, and the low 8 bits hold the byte value. Four flags travel alongside each word:

- a direction flag: 1 means the local end sent the byte, 0 means the far end sent it;
- an error flag;
- a message-start flag;
- a message-end flag.

The block appends one extra word when a message closes. That closing word only carries the end marker, and its byte carries no payload.

The tap runs on the 16 MHz side-band clock. It divides that clock by a parameter to make the microsecond tick. Captured words first pass through a small ordering stage and then through a buffer that can be inferred as block RAM. The downstream consumer drains the buffer with a valid/ready handshake. When the buffer has no room, the newest words are discarded, and a sticky overflow flag records the loss until a clear pulse arrives.

Top module: `aux_trace_tap`

## Requirements
- R1: After reset, `tap_valid` and `ovf_flag` are 0. The stamp counter restarts at 0, so a byte strobed on the first cycle after reset carries stamp 0.
- R2: Word bits [31:8] hold floor(N / TICK_DIV) mod 2^24. N is the number of clock edges since reset, counted before the edge that samples the strobe. The stamp wraps to 0 after 2^24-1 and advances by exactly 1 each time it changes.
- R3: Word bits [7:0] hold the strobed byte. `tap_dir` is 1 for a word from `tx_stb` and 0 for a word from `rx_stb`.
- R4: `tap_err` of a byte word equals the error input that accompanied that strobe (`tx_err` or `rx_err`).
- R5: A `msg_first` pulse sets `tap_sop` on the next captured byte word. That word is in the same cycle if a byte is strobed with the pulse; otherwise it is the first byte in a later cycle. No other word has `tap_sop` set.
- R6: A `msg_last` pulse appends one marker word after the bytes of that cycle. The marker has `tap_eop`=1, `tap_sop`=0, `tap_err`=0, and byte 0x00. Its `tap_dir` equals the direction of the most recent byte; before any byte, `tap_dir` is 1.
- R7: When `tx_stb` and `rx_stb` coincide, the transmit word comes out first, the receive word follows, and any marker comes last. A `msg_first` in that cycle sets `tap_sop` only on the transmit word.
- R8: Words leave in capture order. While `tap_valid`=1 and `tap_ready`=0, `tap_valid` and every output word field hold their values.
- R9: When a word cannot be stored because all buffering is full, that word is dropped and `ovf_flag` becomes 1. Words captured before it remain in order. `ovf_flag` stays 1 until an `ovf_clr` pulse, and a drop in the same cycle as the clear wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Side-band clock (16 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| tx_stb | input | 1 | A byte is being sent by the local end |
| tx_byte | input | 8 | Byte sent |
| tx_err | input | 1 | Error seen on the sent byte |
| rx_stb | input | 1 | A byte was received from the far end |
| rx_byte | input | 8 | Byte received |
| rx_err | input | 1 | Error seen on the received byte |
| msg_first | input | 1 | The next byte opens a message |
| msg_last | input | 1 | The current message has ended |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| tap_ready | input | 1 | Consumer accepts the current word |
| tap_valid | output | 1 | Output word is valid |
| tap_data | output | 32 | Stamp in [31:8], byte in [7:0] |
| tap_sop | output | 1 | First byte of a message |
| tap_eop | output | 1 | End marker word (byte not part of message) |
| tap_err | output | 1 | Byte had an error |
| tap_dir | output | 1 | 1 = sent by local end, 0 = received |
| ovf_flag | output | 1 | Sticky: words were dropped |

## Verification
The stimulus mixes several kinds of traffic, and each kind targets a different fault:

- **Directed single-direction messages.** The start pulse is given both with and without a byte in the same cycle. These messages separate the start-flag pending logic from a simple same-cycle copy.
- **Coincident transmit/receive/end cycles.** These expose a wrong ordering or a misplaced start flag.
- **Seeded random traffic under random backpressure.** This compares the whole word sequence, including every stamp, against a model clocked by the bench's own edge counter. Stamp or order faults show up here.
- **A held-ready phase.** This separates output holding from mere ordering.
- **A long flood with the consumer stalled.** This checks that exactly the newest words are lost, that the flag stays set, and that the clear pulse resets it.

// File: rtl/aux_tap_pkg.sv
`timescale 1ns/1ps
package aux_tap_pkg;
  localparam int TS_W   = 24;
  localparam int BYTE_W = 8;
  localparam int WORD_W = TS_W + BYTE_W;

  localparam logic DIR_LOCAL = 1'b1;
  localparam logic DIR_FAR   = 1'b0;

  typedef struct packed {
    logic              sop;
    logic              eop;
    logic              err;
    logic              dir;
    logic [TS_W-1:0]   ts;
    logic [BYTE_W-1:0] data;
  } tap_word_t;

  localparam int TAP_BITS = $bits(tap_word_t);
endpackage

// File: rtl/aux_tap_timebase.sv
`timescale 1ns/1ps
module aux_tap_timebase #(
  parameter int TICK_DIV = 16,
  parameter int TS_W     = 24
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TS_W-1:0] ts
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre <= '0;
      ts  <= '0;
    end else if (pre == PRE_LAST) begin
      pre <= '0;
      ts  <= ts + TS_W'(1);
    end else begin
      pre <= pre + PW'(1);
    end
  end
endmodule

// File: rtl/aux_tap_stager.sv
`timescale 1ns/1ps
module aux_tap_stager
  import aux_tap_pkg::*;
#(
  parameter int STAGE_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TS_W-1:0]   ts,
  input  logic              tx_stb,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_err,
  input  logic              rx_stb,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_err,
  input  logic              msg_first,
  input  logic              msg_last,
  input  logic              sink_full,
  output logic              wr_en,
  output tap_word_t         wr_word,
  output logic              drop
);
  localparam int NEW = 3;
  localparam int IW  = (STAGE_DEPTH > 1) ? $clog2(STAGE_DEPTH) : 1;
  localparam int CW  = $clog2(STAGE_DEPTH + 1);

  tap_word_t     q   [STAGE_DEPTH];
  tap_word_t     q_n [STAGE_DEPTH];
  logic [CW-1:0] q_cnt, cnt_n;
  logic          sop_pend, last_dir;

  tap_word_t     nw [NEW];
  logic [NEW-1:0] nv;
  logic          first_f, mark_dir, pop;

  // Candidate words of this cycle, in emission order: local, far, marker
  always_comb begin
    first_f  = sop_pend | msg_first;
    mark_dir = rx_stb ? DIR_FAR : (tx_stb ? DIR_LOCAL : last_dir);

    nw[0] = '{sop: first_f, eop: 1'b0, err: tx_err, dir: DIR_LOCAL,
              ts: ts, data: tx_byte};
    nw[1] = '{sop: first_f & ~tx_stb, eop: 1'b0, err: rx_err, dir: DIR_FAR,
              ts: ts, data: rx_byte};
    nw[2] = '{sop: 1'b0, eop: 1'b1, err: 1'b0, dir: mark_dir,
              ts: ts, data: '0};
    nv    = {msg_last, rx_stb, tx_stb};
  end

  assign pop     = (q_cnt != '0) && !sink_full;
  assign wr_en   = pop;
  assign wr_word = q[0];

  always_comb begin
    int fill_v;
    q_n    = q;
    fill_v = int'(q_cnt);
    drop   = 1'b0;
    if (pop) begin
      for (int i = 0; i < STAGE_DEPTH - 1; i++) q_n[i] = q[i+1];
      fill_v = fill_v - 1;
    end
    for (int k = 0; k < NEW; k++) begin
      if (nv[k]) begin
        if (fill_v < STAGE_DEPTH) begin
          q_n[IW'(fill_v)] = nw[k];
          fill_v = fill_v + 1;
        end else begin
          drop = 1'b1;
        end
      end
    end
    cnt_n = CW'(fill_v);
  end

  always_ff @(posedge clk) begin
    q <= q_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_cnt    <= '0;
      sop_pend <= 1'b0;
      last_dir <= DIR_LOCAL;
    end else begin
      q_cnt    <= cnt_n;
      sop_pend <= first_f & ~(tx_stb | rx_stb);
      last_dir <= mark_dir;
    end
  end
endmodule

// File: rtl/aux_tap_fifo.sv
`timescale 1ns/1ps
module aux_tap_fifo #(
  parameter int W     = 36,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         full,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   cnt;
  logic          do_wr, load;

  assign full  = (cnt == (AW+1)'(DEPTH));
  assign do_wr = wr_en && !full;
  assign load  = (cnt != '0) && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)       out_data <= '0;
    else if (load) out_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + AW'(1);
      if (load)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + AW'(1);
      cnt <= cnt + (AW+1)'(do_wr) - (AW+1)'(load);
      if (load)           out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/aux_trace_tap.sv
`timescale 1ns/1ps
module aux_trace_tap
  import aux_tap_pkg::*;
#(
  parameter int TICK_DIV    = 16,
  parameter int FIFO_DEPTH  = 16,
  parameter int STAGE_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_stb,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_err,
  input  logic              rx_stb,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_err,
  input  logic              msg_first,
  input  logic              msg_last,
  input  logic              ovf_clr,
  input  logic              tap_ready,
  output logic              tap_valid,
  output logic [WORD_W-1:0] tap_data,
  output logic              tap_sop,
  output logic              tap_eop,
  output logic              tap_err,
  output logic              tap_dir,
  output logic              ovf_flag
);
  logic [TS_W-1:0] ts_now;
  logic            st_wr, st_drop, buf_full;
  tap_word_t       st_word, out_word;
  logic [TAP_BITS-1:0] out_bits;

  aux_tap_timebase #(.TICK_DIV(TICK_DIV), .TS_W(TS_W)) tb_i (
    .clk(clk), .rst(rst), .ts(ts_now)
  );

  aux_tap_stager #(.STAGE_DEPTH(STAGE_DEPTH)) stg_i (
    .clk(clk), .rst(rst), .ts(ts_now),
    .tx_stb(tx_stb), .tx_byte(tx_byte), .tx_err(tx_err),
    .rx_stb(rx_stb), .rx_byte(rx_byte), .rx_err(rx_err),
    .msg_first(msg_first), .msg_last(msg_last),
    .sink_full(buf_full), .wr_en(st_wr), .wr_word(st_word), .drop(st_drop)
  );

  aux_tap_fifo #(.W(TAP_BITS), .DEPTH(FIFO_DEPTH)) buf_i (
    .clk(clk), .rst(rst), .wr_en(st_wr), .wr_data(st_word), .full(buf_full),
    .out_valid(tap_valid), .out_ready(tap_ready), .out_data(out_bits)
  );

  assign out_word = tap_word_t'(out_bits);
  assign tap_data = {out_word.ts, out_word.data};
  assign tap_sop  = out_word.sop;
  assign tap_eop  = out_word.eop;
  assign tap_err  = out_word.err;
  assign tap_dir  = out_word.dir;

  always_ff @(posedge clk) begin
    if (rst)          ovf_flag <= 1'b0;
    else if (st_drop) ovf_flag <= 1'b1;
    else if (ovf_clr) ovf_flag <= 1'b0;
  end
endmodule

// File: rtl/aux_tap_chk.sv
`timescale 1ns/1ps
module aux_tap_chk #(
  parameter int TS_W = 24
) (
  input logic            clk,
  input logic            rst,
  input logic            tap_valid,
  input logic            tap_ready,
  input logic [31:0]     tap_data,
  input logic            tap_sop,
  input logic            tap_eop,
  input logic            tap_err,
  input logic            tap_dir,
  input logic            ovf_flag,
  input logic            ovf_clr,
  input logic [TS_W-1:0] ts_now
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!tap_valid && !ovf_flag));

  // R2
  ts_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ts_now != $past(ts_now)) |-> (ts_now == $past(ts_now) + TS_W'(1)));

  // R6
  marker_fmt_chk: assert property (@(posedge clk) disable iff (rst)
    (tap_valid && tap_eop) |-> (tap_data[7:0] == 8'h00 && !tap_sop && !tap_err));

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (tap_valid && !tap_ready) |=> (tap_valid && $stable(tap_data) &&
      $stable(tap_sop) && $stable(tap_eop) && $stable(tap_err) && $stable(tap_dir)));

  // R9
  no_overflow_loss_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
endmodule

bind aux_trace_tap aux_tap_chk #(.TS_W(aux_tap_pkg::TS_W)) chk_i (
  .clk(clk), .rst(rst), .tap_valid(tap_valid), .tap_ready(tap_ready),
  .tap_data(tap_data), .tap_sop(tap_sop), .tap_eop(tap_eop),
  .tap_err(tap_err), .tap_dir(tap_dir), .ovf_flag(ovf_flag),
  .ovf_clr(ovf_clr), .ts_now(ts_now)
);

// File: tb/aux_trace_tap_tb.sv
`timescale 1ns/1ps
module aux_trace_tap_tb_top;
  localparam int TICK_DIV = 16;
  localparam int WD_CYC   = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic d_tx = 0, d_txe = 0, d_rx = 0, d_rxe = 0, d_first = 0, d_last = 0, d_clr = 0;
  logic [7:0] d_txb = 0, d_rxb = 0;
  logic d_ready = 1'b1;
  logic tap_valid, tap_sop, tap_eop, tap_err, tap_dir, ovf_flag;
  logic [31:0] tap_data;

  int n_chk = 0;
  int n_fail = 0;
  int nb = 0;
  logic m_sop = 0, m_dir = 1;
  logic [35:0] exp_q[$];
  logic [35:0] got_q[$];

  always #5 clk = ~clk;

  aux_trace_tap #(.TICK_DIV(TICK_DIV), .FIFO_DEPTH(16), .STAGE_DEPTH(4)) dut_i (
    .clk(clk), .rst(rst),
    .tx_stb(d_tx), .tx_byte(d_txb), .tx_err(d_txe),
    .rx_stb(d_rx), .rx_byte(d_rxb), .rx_err(d_rxe),
    .msg_first(d_first), .msg_last(d_last), .ovf_clr(d_clr),
    .tap_ready(d_ready), .tap_valid(tap_valid), .tap_data(tap_data),
    .tap_sop(tap_sop), .tap_eop(tap_eop), .tap_err(tap_err),
    .tap_dir(tap_dir), .ovf_flag(ovf_flag)
  );

  // Reference model and collector, sampled mid-cycle
  always @(negedge clk) begin
    logic [23:0] tsv;
    logic first;
    if (rst) begin
      nb = 0; m_sop = 0; m_dir = 1;
    end else begin
      tsv   = 24'(nb / TICK_DIV);
      first = m_sop | d_first;
      if (d_tx) exp_q.push_back({first, 1'b0, d_txe, 1'b1, tsv, d_txb});
      if (d_rx) exp_q.push_back({first & !d_tx, 1'b0, d_rxe, 1'b0, tsv, d_rxb});
      if (d_rx) m_dir = 1'b0;
      else if (d_tx) m_dir = 1'b1;
      if (d_last) exp_q.push_back({1'b0, 1'b1, 1'b0, m_dir, tsv, 8'h00});
      m_sop = first & !(d_tx | d_rx);
      nb++;
      if (tap_valid && d_ready)
        got_q.push_back({tap_sop, tap_eop, tap_err, tap_dir, tap_data});
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic step(input logic tx, input logic [7:0] txb, input logic txe,
                      input logic rx, input logic [7:0] rxb, input logic rxe,
                      input logic f, input logic l);
    d_tx = tx; d_txb = txb; d_txe = txe;
    d_rx = rx; d_rxb = rxb; d_rxe = rxe;
    d_first = f; d_last = l;
    @(posedge clk); #2;
    d_tx = 0; d_rx = 0; d_txe = 0; d_rxe = 0; d_first = 0; d_last = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
  endtask

  task automatic compare_streams(input string tag);
    int n;
    d_ready = 1'b1;
    idle(40);
    chk(got_q.size() == exp_q.size(), {tag, " word count"}, 36'(got_q.size()), 36'(exp_q.size()));
    n = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
    for (int i = 0; i < n; i++)
      chk(got_q[i] === exp_q[i], tag, got_q[i], exp_q[i]);
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(WD_CYC * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [35:0] held;
    void'($urandom(32'h1A2B3C4D));
    #2;
    do_reset();

    // R1: idle after reset, stamp origin
    chk(tap_valid == 1'b0, "R1 valid after reset", 36'(tap_valid), 36'd0);
    chk(ovf_flag == 1'b0, "R1 ovf after reset", 36'(ovf_flag), 36'd0);
    step(1, 8'hA5, 0, 0, 0, 0, 1, 0);
    idle(6);
    chk(got_q.size() > 0 && got_q[0][31:8] == 24'd0, "R1 first stamp",
        (got_q.size() > 0) ? 36'(got_q[0][31:8]) : 36'hFFFFFFFFF, 36'd0);
    compare_streams("R1 R2 R3 R5 first word");

    // R3 R4 R5 R6: request then reply, start pulse without a byte
    step(1, 8'h90, 0, 0, 0, 0, 1, 0);
    step(1, 8'h00, 0, 0, 0, 0, 0, 0);
    step(1, 8'h20, 0, 0, 0, 0, 0, 0);
    step(1, 8'h03, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    idle(30);
    step(0, 0, 0, 0, 0, 0, 1, 0);
    idle(2);
    step(0, 0, 0, 1, 8'h00, 0, 0, 0);
    step(0, 0, 0, 1, 8'h5C, 1, 0, 0);
    step(0, 0, 0, 1, 8'h7E, 0, 0, 1);
    compare_streams("R3 R4 R5 R6 R2 directed message");

    // R6: marker before any byte after reset uses direction 1
    do_reset();
    step(0, 0, 0, 0, 0, 0, 0, 1);
    compare_streams("R6 marker default direction");

    // R7: coincident strobes with start and end
    step(1, 8'h11, 0, 1, 8'h22, 1, 1, 1);
    step(1, 8'h33, 1, 1, 8'h44, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    compare_streams("R7 coincident order");

    // R8: output held under backpressure
    d_ready = 1'b0;
    step(1, 8'hC1, 0, 0, 0, 0, 1, 0);
    step(1, 8'hC2, 1, 0, 0, 0, 0, 1);
    idle(6);
    @(negedge clk);
    held = {tap_sop, tap_eop, tap_err, tap_dir, tap_data};
    chk(tap_valid == 1'b1, "R8 valid while stalled", 36'(tap_valid), 36'd1);
    repeat (3) @(negedge clk);
    chk({tap_sop, tap_eop, tap_err, tap_dir, tap_data} === held && tap_valid,
        "R8 word held", {tap_sop, tap_eop, tap_err, tap_dir, tap_data}, held);
    @(posedge clk); #2;
    compare_streams("R8 stalled order");

    // R7 R8 R2: seeded random traffic with random backpressure
    for (int i = 0; i < 600; i++) begin
      logic tx, rx, f, l;
      int r;
      r  = $urandom_range(0, 99);
      tx = (r < 20);
      rx = (r >= 20 && r < 40) || (r < 3);
      f  = ($urandom_range(0, 9) == 0);
      l  = ($urandom_range(0, 11) == 0);
      d_ready = ($urandom_range(0, 9) < 8);
      step(tx, 8'($urandom), ($urandom_range(0, 7) == 0),
           rx, 8'($urandom), ($urandom_range(0, 7) == 0), f, l);
    end
    chk(ovf_flag == 1'b0, "R9 no loss in random phase", 36'(ovf_flag), 36'd0);
    compare_streams("R7 R8 R2 random traffic");

    // R9: flood with consumer stalled
    d_ready = 1'b0;
    for (int i = 0; i < 40; i++) step(1, 8'(i), 0, 0, 0, 0, (i == 0), 0);
    idle(3);
    chk(ovf_flag == 1'b1, "R9 overflow set", 36'(ovf_flag), 36'd1);
    d_ready = 1'b1;
    idle(40);
    chk(ovf_flag == 1'b1, "R9 flag sticky after drain", 36'(ovf_flag), 36'd1);
    chk(got_q.size() < exp_q.size() && got_q.size() > 0, "R9 newest dropped",
        36'(got_q.size()), 36'(exp_q.size()));
    for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
      chk(got_q[i] === exp_q[i], "R9 kept prefix", got_q[i], exp_q[i]);
    got_q.delete();
    exp_q.delete();
    d_clr = 1'b1;
    idle(1);
    d_clr = 1'b0;
    idle(1);
    chk(ovf_flag == 1'b0, "R9 cleared", 36'(ovf_flag), 36'd0);

    // R9: drop coinciding with clear keeps the flag
    d_ready = 1'b0;
    for (int i = 0; i < 30; i++) begin
      d_clr = (i == 29);
      step(1, 8'(i), 0, 0, 0, 0, 0, 0);
    end
    d_clr = 1'b0;
    idle(1);
    chk(ovf_flag == 1'b1, "R9 drop wins over clear", 36'(ovf_flag), 36'd1);
    d_ready = 1'b1;
    idle(40);
    got_q.delete();
    exp_q.delete();

    finish_run();
  end
endmodule